// File: doc/BRIEF.md
# PWM Output Steering Unit

This unit sends a single PWM waveform to any chosen group of four output pins. A per-pin steering bit decides what each pin carries: the PWM signal when the bit is set, or that pin's general-purpose port data when it is clear. A direction bit per pin controls whether the pin is driven at all.

Software writes the steering bits and a sync-mode bit through a single write strobe. The written value first lands in a shadow register. It moves to the active register either on the next clock or at the next PWM period-start strobe, depending on the sync-mode bit that was written with it. Synchronized mode makes sure a pin is never switched part way through a PWM period.

Steering works only in single-output configuration, where the bridge mode field is 00 and the PWM mode field is 11. In any other configuration every pin carries port data. Pin outputs and output enables are registered.

Top module: `pwm_steer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the shadow and active steering bits, clears the sync-mode bit and any pending update, and drives pin_out and pin_oe to 0. From the first edge after reset, every enabled pin carries port data.
- R2: One edge after inputs are sampled, pin_out[i] equals pwm_in if active steering bit i is set and the configuration is valid. Otherwise it equals port_data[i].
- R3: A write with wr_sync=0 loads the shadow register at edge k and the active register at edge k+1. Pins show the new selection from edge k+2.
- R4: A write with wr_sync=1 stays pending. The active register is not changed at any edge where period_start is low, so the pins keep the previous selection.
- R5: In sync mode, when several writes occur before a period start, only the last written value is committed.
- R6: If period_start is high at the edge where the pending value is committed, the shadow value from before that edge is committed. A write at that same edge stays pending until the next period start.
- R7: pin_oe[i] is registered from pin_dir[i], where 0 means output (driven) and 1 means released (pin_oe=0). This holds whatever the steering selection is.
- R8: Steering is valid only when bridge_cfg is 2'b00 and pwm_cfg is 2'b11. In any other configuration, pin_out equals port_data, registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the steering register |
| wr_steer | input | NUM_PINS | Steering bits to write, one per pin |
| wr_sync | input | 1 | Sync-mode bit to write: 1 commits at the period start |
| bridge_cfg | input | 2 | Bridge mode field; must be 00 for steering |
| pwm_cfg | input | 2 | PWM mode field; must be 11 for steering |
| pwm_in | input | 1 | PWM waveform from the generator |
| period_start | input | 1 | One-cycle strobe at the start of a PWM period |
| port_data | input | NUM_PINS | Port data latch value for each pin |
| pin_dir | input | NUM_PINS | Direction per pin: 0 output, 1 released |
| pin_out | output | NUM_PINS | Registered pin value |
| pin_oe | output | NUM_PINS | Registered output enable per pin |

## Verification
The bench targets the timing of the commit. It checks that an immediate write appears on the pins exactly two edges later, which catches a design with an extra or a missing stage. It checks that a synchronized write does not move the pins before the period strobe, which catches a design that commits at once. It checks that the last of several writes is the one committed, which catches a design that keeps the first. It checks that a write landing on the strobe edge is deferred to the next period, which catches a design that commits the newest value early. Separate checks with the direction bits and with invalid configurations catch a design that lets steering drive a released pin, or that steers in a bridge configuration.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam logic [1:0] BRIDGE_SINGLE = 2'b00;
  localparam logic [1:0] PWM_MODE_OK   = 2'b11;

  function automatic logic cfg_allows_steer(input logic [1:0] bridge,
                                            input logic [1:0] pwm_mode);
    return (bridge == BRIDGE_SINGLE) && (pwm_mode == PWM_MODE_OK);
  endfunction
endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_steer,
  input  logic                wr_sync,
  input  logic                period_start,
  output logic [NUM_PINS-1:0] shadow_steer,
  output logic [NUM_PINS-1:0] active_steer,
  output logic                sync_mode,
  output logic                pending
);
  logic commit;

  // A pending value moves at once, or only on a period boundary in sync mode
  assign commit = pending && (!sync_mode || period_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_steer <= '0;
      sync_mode    <= 1'b0;
      pending      <= 1'b0;
    end else if (wr_en) begin
      shadow_steer <= wr_steer;
      sync_mode    <= wr_sync;
      pending      <= 1'b1;
    end else if (commit) begin
      pending      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_steer <= '0;
    end else if (commit) begin
      active_steer <= shadow_steer;
    end
  end
endmodule

// File: rtl/pwm_steer_pin_drv.sv
module pwm_steer_pin_drv #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                steer_ok,
  input  logic [NUM_PINS-1:0] active_steer,
  input  logic                pwm_in,
  input  logic [NUM_PINS-1:0] port_data,
  input  logic [NUM_PINS-1:0] pin_dir,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic sel_pwm;
    assign sel_pwm = steer_ok && active_steer[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else begin
        pin_out[i] <= sel_pwm ? pwm_in : port_data[i];
        pin_oe[i]  <= ~pin_dir[i];
      end
    end
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_steer,
  input  logic                wr_sync,
  input  logic [1:0]          bridge_cfg,
  input  logic [1:0]          pwm_cfg,
  input  logic                pwm_in,
  input  logic                period_start,
  input  logic [NUM_PINS-1:0] port_data,
  input  logic [NUM_PINS-1:0] pin_dir,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic [NUM_PINS-1:0] shadow_steer;
  logic [NUM_PINS-1:0] active_steer;
  logic                sync_mode;
  logic                pending;
  logic                steer_ok;

  assign steer_ok = cfg_allows_steer(bridge_cfg, pwm_cfg);

  pwm_steer_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_steer     (wr_steer),
    .wr_sync      (wr_sync),
    .period_start (period_start),
    .shadow_steer (shadow_steer),
    .active_steer (active_steer),
    .sync_mode    (sync_mode),
    .pending      (pending)
  );

  pwm_steer_pin_drv #(.NUM_PINS(NUM_PINS)) u_drv (
    .clk          (clk),
    .rst          (rst),
    .steer_ok     (steer_ok),
    .active_steer (active_steer),
    .pwm_in       (pwm_in),
    .port_data    (port_data),
    .pin_dir      (pin_dir),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
  );
endmodule

// File: rtl/pwm_steer_sva.sv
module pwm_steer_sva #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                period_start,
  input logic                steer_ok,
  input logic [NUM_PINS-1:0] port_data,
  input logic [NUM_PINS-1:0] pin_dir,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] shadow_steer,
  input logic [NUM_PINS-1:0] active_steer,
  input logic                sync_mode,
  input logic                pending
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (active_steer == '0 && !pending && !sync_mode && pin_oe == '0));

  a_r2_idle_carries_port: assert property (@(posedge clk) disable iff (rst)
    (active_steer == '0) |=> (pin_out == $past(port_data)));

  a_r3_immediate_commit: assert property (@(posedge clk) disable iff (rst)
    (pending && !sync_mode) |=> (active_steer == $past(shadow_steer)));

  a_r4_hold_until_period: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && !period_start) |=> $stable(active_steer));

  a_r6_boundary_commit: assert property (@(posedge clk) disable iff (rst)
    (pending && sync_mode && period_start) |=>
      (active_steer == $past(shadow_steer) && (pending == $past(wr_en))));

  a_r7_direction: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pin_oe == ~$past(pin_dir)));

  a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
    !steer_ok |=> (pin_out == $past(port_data)));
endmodule

bind pwm_steer pwm_steer_sva #(.NUM_PINS(NUM_PINS)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .period_start (period_start),
  .steer_ok     (steer_ok),
  .port_data    (port_data),
  .pin_dir      (pin_dir),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .shadow_steer (shadow_steer),
  .active_steer (active_steer),
  .sync_mode    (sync_mode),
  .pending      (pending)
);

// File: tb/test_pwm_steer.sv
module test_pwm_steer;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_steer = '0;
  logic         wr_sync = 1'b0;
  logic [1:0]   bridge_cfg = 2'b00;
  logic [1:0]   pwm_cfg = 2'b11;
  logic         pwm_in = 1'b0;
  logic         period_start = 1'b0;
  logic [N-1:0] port_data = '0;
  logic [N-1:0] pin_dir = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwm_steer #(.NUM_PINS(N)) i_pwm_steer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_steer(wr_steer), .wr_sync(wr_sync),
    .bridge_cfg(bridge_cfg), .pwm_cfg(pwm_cfg), .pwm_in(pwm_in),
    .period_start(period_start), .port_data(port_data), .pin_dir(pin_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Reference model built from the requirements
  logic [N-1:0] m_sh, m_ac, m_out, m_oe;
  logic         m_sy, m_pe;

  function automatic logic [N-1:0] exp_pins(logic [N-1:0] act, logic pwm,
                                            logic [N-1:0] port, logic [1:0] br,
                                            logic [1:0] pm);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = (br == 2'b00 && pm == 2'b11 && act[i]) ? pwm : port[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sh <= '0; m_ac <= '0; m_sy <= 1'b0; m_pe <= 1'b0;
      m_out <= '0; m_oe <= '0;
    end else begin
      m_out <= exp_pins(m_ac, pwm_in, port_data, bridge_cfg, pwm_cfg);
      m_oe  <= ~pin_dir;
      if (m_pe && (!m_sy || period_start)) m_ac <= m_sh;
      if (wr_en) begin
        m_sh <= wr_steer; m_sy <= wr_sync; m_pe <= 1'b1;
      end else if (m_pe && (!m_sy || period_start)) begin
        m_pe <= 1'b0;
      end
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Continuous comparison against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 R3 R4 R5 R6 pin_out model", pin_out, m_out);
      check("R7 pin_oe model", pin_oe, m_oe);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [N-1:0] s, logic sy);
    wr_en = 1'b1; wr_steer = s; wr_sync = sy;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    // R1: reset state
    check("R1 pin_out in reset", pin_out, '0);
    check("R1 pin_oe in reset", pin_oe, '0);
    rst = 1'b0; port_data = 4'b1010; pwm_in = 1'b1;
    tick();
    check("R1 pins carry port data", pin_out, 4'b1010);
    check("R1 pins driven", pin_oe, 4'b1111);

    // R3: immediate commit latency
    port_data = 4'b0000;
    wr(4'b0101, 1'b0); tick(); wr_en = 1'b0;
    tick();
    check("R3 unchanged after one edge", pin_out, 4'b0000);
    tick();
    check("R3 new selection at k+2", pin_out, 4'b0101);

    // R4: sync write held until period start
    wr(4'b1111, 1'b1); tick(); wr_en = 1'b0;
    tick(5);
    check("R4 held before boundary", pin_out, 4'b0101);
    period_start = 1'b1; tick(); period_start = 1'b0;
    tick();
    check("R4 applied after boundary", pin_out, 4'b1111);

    // R5: last write wins
    wr(4'b0001, 1'b1); tick();
    wr(4'b0010, 1'b1); tick();
    wr(4'b1000, 1'b1); tick(); wr_en = 1'b0;
    tick(2);
    check("R5 still old before boundary", pin_out, 4'b1111);
    period_start = 1'b1; tick(); period_start = 1'b0;
    tick();
    check("R5 last write committed", pin_out, 4'b1000);

    // R6: write coinciding with period start
    wr(4'b0100, 1'b1); tick();
    wr(4'b0011, 1'b1); period_start = 1'b1; tick();
    wr_en = 1'b0; period_start = 1'b0;
    tick();
    check("R6 older shadow committed", pin_out, 4'b0100);
    tick(3);
    check("R6 new write still pending", pin_out, 4'b0100);
    period_start = 1'b1; tick(); period_start = 1'b0;
    tick();
    check("R6 deferred write committed", pin_out, 4'b0011);

    // R7: direction controls drive
    pin_dir = 4'b1111; tick();
    check("R7 all released", pin_oe, 4'b0000);
    check("R7 value independent of direction", pin_out, 4'b0011);
    pin_dir = 4'b0101; tick();
    check("R7 mixed direction", pin_oe, 4'b1010);
    pin_dir = 4'b0000;

    // R8: invalid configuration bypasses steering
    port_data = 4'b0110; pwm_in = 1'b1;
    bridge_cfg = 2'b01; tick();
    check("R8 bridge mode bypass", pin_out, 4'b0110);
    bridge_cfg = 2'b00; pwm_cfg = 2'b10; tick();
    check("R8 pwm mode bypass", pin_out, 4'b0110);
    pwm_cfg = 2'b11; tick();
    check("R8 steering restored", pin_out, 4'b0111);

    // Random phase, checked by the model (R2 R3 R4 R5 R6 R7 R8)
    for (int c = 0; c < 4000; c++) begin
      wr_en        = ($urandom_range(7) == 0);
      wr_steer     = N'($urandom);
      wr_sync      = $urandom_range(1);
      period_start = ($urandom_range(9) == 0);
      pwm_in       = $urandom_range(1);
      port_data    = N'($urandom);
      pin_dir      = ($urandom_range(3) == 0) ? N'($urandom) : '0;
      bridge_cfg   = ($urandom_range(9) == 0) ? 2'($urandom) : 2'b00;
      pwm_cfg      = ($urandom_range(9) == 0) ? 2'($urandom) : 2'b11;
      if (c == 2000) rst = 1'b1;
      if (c == 2003) rst = 1'b0;
      tick();
    end
    wr_en = 1'b0;
    tick(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule